// File: doc/BRIEF.md
# Binary Synchronous Receive Message Controller

This block sits behind a character-synchronous receiver that has already turned the line into bytes. It follows a binary synchronous message protocol on that byte stream. While idle it hunts for character sync: one or two back-to-back sync characters, chosen by configuration. Once in sync it passes message bytes downstream. It marks the first byte with a start flag and the closing control byte with an end flag. It removes sync fill and handles the data-link-escape sequences of transparent text. It then drops back to hunting by itself.

Normal and transparent text follow different rules. In normal text, sync fill may be stripped, and a bare text terminator ends the message. An escape followed by start-of-text switches the block into transparent text. In transparent text, every byte is data, including sync and terminator codes, except when it follows an escape character. The escape pairs produce a literal escape byte, discarded fill, or the end of the message. After a message that ends with end-of-transmission or negative acknowledge, the next byte is checked as a closing pad before hunting resumes.

The control-code set is chosen at run time: ASCII or EBCDIC. Each accepted byte gives at most one output byte, registered one cycle later.

Top module: `bisync_rx_ctl`

## Requirements
- R1: From hunt, sync is gained after one sync character when `cfg_two_syn`=0. When it is 1, sync needs two consecutive sync characters, and a non-sync byte after a single sync returns the block to hunt. `hunting` is 1 while the block searches for sync.
- R2: While hunting, bytes produce no output.
- R3: In normal text, sync characters that arrive before the first message byte are always discarded. Later sync characters are discarded when `cfg_strip_syn`=1 and passed on as data when it is 0.
- R4: The first output byte of a message has `out_som`=1. In normal text, a terminator (ETX, ETB or ENQ) is output with `out_eom`=1, and the block then returns to hunt.
- R5: In normal text, escape (DLE) followed by STX is passed on as two normal bytes. Every later byte is in transparent text, output with `out_xpar`=1.
- R6: In transparent text, escape is never output by itself. DLE DLE gives one data byte 0x10. DLE SYN is discarded. DLE followed by a terminator outputs that terminator with `out_eom`=1 and returns to hunt. DLE followed by any other byte outputs that byte as data.
- R7: In transparent text, a sync or terminator code not preceded by DLE is ordinary data, without `out_eom`.
- R8: EOT or NAK in normal text is output with `out_eom`=1. The next byte is a closing pad and is not output. The pad is valid when its low four bits are all ones. An invalid pad gives a one-cycle `out_pad_err` pulse in the cycle after the pad is accepted. Hunt resumes after the pad.
- R9: Control codes, used when `cfg_ascii`=1 and 0 respectively, are SYN 0x16/0x32, DLE 0x10/0x10, STX 0x02/0x02, ETX 0x03/0x03, ETB 0x17/0x26, ENQ 0x05/0x2D, EOT 0x04/0x37 and NAK 0x15/0x3D.
- R10: An output byte appears with `out_valid`=1 on the clock edge after the edge that accepted its input byte. Cycles without `in_valid` change nothing and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_two_syn | input | 1 | 1: two sync characters needed for sync |
| cfg_strip_syn | input | 1 | 1: remove sync fill inside normal text |
| cfg_ascii | input | 1 | 1: ASCII control codes, 0: EBCDIC |
| in_valid | input | 1 | Received byte present |
| in_data | input | 8 | Received byte |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_som | output | 1 | First byte of message |
| out_eom | output | 1 | Closing byte of message |
| out_xpar | output | 1 | Byte received in transparent text |
| out_pad_err | output | 1 | Closing pad was invalid (pulse) |
| hunting | output | 1 | Searching for character sync |

## Verification
The bench aims at the escape pairs in transparent text. A design that stripped escapes without looking at the next byte would lose the literal 0x10 or leak fill. One that ignored the mode would end a transparent message on a bare ETX, or drop a transparent sync byte. Broken single sync in two-sync mode, leading sync that would be wrongly output as data, and sync fill with stripping on and off are all covered, along with good and bad closing pads after EOT and NAK. An EBCDIC pass confirms that ASCII codes are then treated as plain data and that the other terminator set ends messages.

// File: rtl/bsc_pkg.sv
// Shared types for the binary synchronous receive controller.
// Assumes 8-bit characters; control codes are fixed per code set.
package bsc_pkg;

    typedef enum logic [2:0] {
        ST_HUNT = 3'd0,   // searching for sync
        ST_SYN1 = 3'd1,   // one sync seen, second needed
        ST_NORM = 3'd2,   // normal text
        ST_XPAR = 3'd3,   // transparent text
        ST_XDLE = 3'd4,   // transparent text after escape
        ST_PAD  = 3'd5    // awaiting closing pad
    } bsc_state_t;

    typedef struct packed {
        logic is_syn;
        logic is_dle;
        logic is_stx;
        logic is_term;    // ETX, ETB or ENQ
        logic is_eotnak;  // EOT or NAK
    } bsc_cls_t;

endpackage

// File: rtl/bsc_codec.sv
// Classifies one received character against the control codes of the
// selected code set. Purely combinational; assumes W >= 8.
module bsc_codec #(
    parameter int W = 8
) (
    input  logic         cfg_ascii,
    input  logic [W-1:0] chr,
    output bsc_pkg::bsc_cls_t cls
);
    logic [7:0] c_syn, c_etb, c_enq, c_eot, c_nak;
    localparam logic [7:0] C_DLE = 8'h10;
    localparam logic [7:0] C_STX = 8'h02;
    localparam logic [7:0] C_ETX = 8'h03;

    // Select code-set dependent values.
    always_comb begin
        if (cfg_ascii) begin
            c_syn = 8'h16; c_etb = 8'h17; c_enq = 8'h05;
            c_eot = 8'h04; c_nak = 8'h15;
        end else begin
            c_syn = 8'h32; c_etb = 8'h26; c_enq = 8'h2D;
            c_eot = 8'h37; c_nak = 8'h3D;
        end
    end

    // Compare the character with each code.
    always_comb begin
        cls.is_syn    = (chr[7:0] == c_syn);
        cls.is_dle    = (chr[7:0] == C_DLE);
        cls.is_stx    = (chr[7:0] == C_STX);
        cls.is_term   = (chr[7:0] == C_ETX) || (chr[7:0] == c_etb) ||
                        (chr[7:0] == c_enq);
        cls.is_eotnak = (chr[7:0] == c_eot) || (chr[7:0] == c_nak);
    end
endmodule

// File: rtl/bsc_msg_fsm.sv
// Message state machine: sync hunt, normal/transparent text, escape
// handling, end of message and closing-pad check. Registers one output
// per accepted byte. Assumes cfg inputs change only while hunting.
module bsc_msg_fsm #(
    parameter int W        = 8,
    parameter int PAD_ONES = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_two_syn,
    input  logic         cfg_strip_syn,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  bsc_pkg::bsc_cls_t cls,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         out_som,
    output logic         out_eom,
    output logic         out_xpar,
    output logic         out_pad_err,
    output logic         hunting
);
    import bsc_pkg::*;

    localparam logic [W-1:0] DLE_CHR = W'(8'h10);

    bsc_state_t st_q;
    logic       first_q;   // no byte output yet in this message
    logic       dle_q;     // last normal byte was escape

    // State, flags and registered output for each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_HUNT;
            first_q     <= 1'b1;
            dle_q       <= 1'b0;
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_som     <= 1'b0;
            out_eom     <= 1'b0;
            out_xpar    <= 1'b0;
            out_pad_err <= 1'b0;
        end else begin
            out_valid   <= 1'b0;
            out_som     <= 1'b0;
            out_eom     <= 1'b0;
            out_xpar    <= 1'b0;
            out_pad_err <= 1'b0;
            out_data    <= in_data;
            if (in_valid) begin
                case (st_q)
                    ST_HUNT: begin
                        first_q <= 1'b1;
                        dle_q   <= 1'b0;
                        if (cls.is_syn) st_q <= cfg_two_syn ? ST_SYN1 : ST_NORM;
                    end
                    ST_SYN1: st_q <= cls.is_syn ? ST_NORM : ST_HUNT;
                    ST_NORM: begin
                        if (!(cls.is_syn && (first_q || cfg_strip_syn))) begin
                            out_valid <= 1'b1;
                            out_som   <= first_q;
                            first_q   <= 1'b0;
                            dle_q     <= cls.is_dle;
                            if (cls.is_term) begin
                                out_eom <= 1'b1;
                                st_q    <= ST_HUNT;
                            end else if (cls.is_eotnak) begin
                                out_eom <= 1'b1;
                                st_q    <= ST_PAD;
                            end else if (cls.is_stx && dle_q) begin
                                st_q <= ST_XPAR;
                            end
                        end
                    end
                    ST_XPAR: begin
                        if (cls.is_dle) begin
                            st_q <= ST_XDLE;
                        end else begin
                            out_valid <= 1'b1;
                            out_xpar  <= 1'b1;
                        end
                    end
                    ST_XDLE: begin
                        st_q <= ST_XPAR;
                        if (!cls.is_syn) begin
                            out_valid <= 1'b1;
                            out_xpar  <= 1'b1;
                            out_data  <= cls.is_dle ? DLE_CHR : in_data;
                        end
                        if (cls.is_term) begin
                            out_eom <= 1'b1;
                            st_q    <= ST_HUNT;
                        end
                    end
                    ST_PAD: begin
                        out_pad_err <= ~&in_data[PAD_ONES-1:0];
                        st_q        <= ST_HUNT;
                    end
                    default: st_q <= ST_HUNT;
                endcase
            end
        end
    end

    // Hunt indication from the state register.
    assign hunting = (st_q == ST_HUNT) || (st_q == ST_SYN1);

    // R2: a byte taken while hunting gives no output.
    p_hunt_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hunting && in_valid) |=> !out_valid);
    // R10: an idle cycle produces nothing.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R4: message marks only accompany a valid byte.
    p_marks_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_som || out_eom) |-> out_valid);
    // R4: after a message end the block hunts or waits for the pad.
    p_eom_leaves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_eom |-> (hunting || st_q == ST_PAD));
    // R8: pad error is a single-cycle pulse followed by hunt.
    p_pad_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_pad_err |-> (hunting && !out_valid));
    // R6: an escape state never survives a received byte.
    p_xdle_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_XDLE && in_valid) |=> (st_q != ST_XDLE));
endmodule

// File: rtl/bisync_rx_ctl.sv
// Top of the binary synchronous receive message controller: character
// classifier feeding the message state machine. Input bytes come from a
// character-synchronous receiver; outputs go to a message buffer.
module bisync_rx_ctl #(
    parameter int W        = 8,
    parameter int PAD_ONES = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_two_syn,
    input  logic         cfg_strip_syn,
    input  logic         cfg_ascii,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         out_som,
    output logic         out_eom,
    output logic         out_xpar,
    output logic         out_pad_err,
    output logic         hunting
);
    bsc_pkg::bsc_cls_t cls;

    bsc_codec #(.W(W)) codec_i (
        .cfg_ascii (cfg_ascii),
        .chr       (in_data),
        .cls       (cls)
    );

    bsc_msg_fsm #(.W(W), .PAD_ONES(PAD_ONES)) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_two_syn   (cfg_two_syn),
        .cfg_strip_syn (cfg_strip_syn),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .cls           (cls),
        .out_valid     (out_valid),
        .out_data      (out_data),
        .out_som       (out_som),
        .out_eom       (out_eom),
        .out_xpar      (out_xpar),
        .out_pad_err   (out_pad_err),
        .hunting       (hunting)
    );
endmodule

// File: tb/bisync_rx_ctl_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected output items, the monitor
// pops and compares them as the design emits bytes.
module bisync_rx_ctl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_two_syn = 1'b0, cfg_strip_syn = 1'b1, cfg_ascii = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic out_valid, out_som, out_eom, out_xpar, out_pad_err, hunting;
    logic [7:0] out_data;

    int checks = 0;
    int failures = 0;
    int pad_cnt = 0;
    logic [10:0] exp_q[$];   // {xpar, eom, som, data}
    string       tag_q[$];

    always #2.5 clk = ~clk;

    bisync_rx_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_two_syn(cfg_two_syn),
        .cfg_strip_syn(cfg_strip_syn), .cfg_ascii(cfg_ascii),
        .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid),
        .out_data(out_data), .out_som(out_som), .out_eom(out_eom),
        .out_xpar(out_xpar), .out_pad_err(out_pad_err), .hunting(hunting)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input int gap);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < gap; i++) @(negedge clk);
    endtask

    task automatic expect_b(input logic [7:0] d, input logic som, input logic eom,
                            input logic xp, input string req);
        exp_q.push_back({xp, eom, som, d});
        tag_q.push_back(req);
    endtask

    task automatic drain(input string req);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
        chk(hunting == 1'b1, req, hunting, 1);
    endtask

    // Monitor: compare each emitted byte against the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_pad_err) pad_cnt++;
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected output", {out_xpar, out_eom, out_som, out_data}, 0);
                end else begin
                    logic [10:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({out_xpar, out_eom, out_som, out_data} == e, t,
                        {out_xpar, out_eom, out_som, out_data}, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #500000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R1, R10).
        chk(out_valid == 1'b0, "R10 reset valid", out_valid, 0);
        chk(hunting == 1'b1, "R1 reset hunting", hunting, 1);
        chk(out_pad_err == 1'b0, "R8 reset pad_err", out_pad_err, 0);

        // R2: junk while hunting gives nothing.
        send(8'h41, 0); send(8'h03, 1); send(8'h02, 0);
        drain("R2 hunt junk");

        // R1: two-sync mode, broken single sync returns to hunt.
        cfg_two_syn = 1'b1;
        send(8'h16, 0);
        chk(hunting == 1'b1, "R1 one of two syncs", hunting, 1);
        send(8'h41, 0);
        chk(hunting == 1'b1, "R1 broken sync", hunting, 1);
        send(8'h16, 0); send(8'h16, 2);
        chk(hunting == 1'b0, "R1 sync gained", hunting, 0);
        // R3 strip on, R4 som/eom with ETX.
        send(8'h16, 0);                       // leading sync discarded
        expect_b(8'h01, 1, 0, 0, "R4 som"); send(8'h01, 0);
        expect_b(8'h41, 0, 0, 0, "R3 data"); send(8'h41, 1);
        send(8'h16, 0);                       // stripped fill
        expect_b(8'h42, 0, 0, 0, "R3 after strip"); send(8'h42, 0);
        expect_b(8'h03, 0, 1, 0, "R4 ETX eom"); send(8'h03, 0);
        drain("R4 back to hunt");

        // R3 strip off: inner sync is data; ETB ends.
        cfg_strip_syn = 1'b0;
        send(8'h16, 0); send(8'h16, 0); send(8'h16, 0);
        expect_b(8'h02, 1, 0, 0, "R3 first byte"); send(8'h02, 0);
        expect_b(8'h16, 0, 0, 0, "R3 sync kept"); send(8'h16, 0);
        expect_b(8'h43, 0, 0, 0, "R3 data"); send(8'h43, 0);
        expect_b(8'h17, 0, 1, 0, "R4 ETB eom"); send(8'h17, 0);
        drain("R4 ETB hunt");

        // R5/R6/R7: transparent text, one-sync mode.
        cfg_two_syn = 1'b0; cfg_strip_syn = 1'b1;
        send(8'h16, 0);
        chk(hunting == 1'b0, "R1 single sync", hunting, 0);
        expect_b(8'h10, 1, 0, 0, "R5 DLE normal"); send(8'h10, 0);
        expect_b(8'h02, 0, 0, 0, "R5 STX normal"); send(8'h02, 0);
        expect_b(8'h16, 0, 0, 1, "R7 sync is data"); send(8'h16, 0);
        send(8'h10, 0);
        expect_b(8'h10, 0, 0, 1, "R6 DLE DLE"); send(8'h10, 0);
        send(8'h10, 1); send(8'h16, 0);       // DLE SYN fill
        expect_b(8'h03, 0, 0, 1, "R7 bare ETX data"); send(8'h03, 0);
        send(8'h10, 0);
        expect_b(8'h5A, 0, 0, 1, "R6 DLE other"); send(8'h5A, 0);
        chk(hunting == 1'b0, "R7 still in message", hunting, 0);
        send(8'h10, 0);
        expect_b(8'h05, 0, 1, 1, "R6 DLE ENQ eom"); send(8'h05, 0);
        drain("R6 transparent end");

        // R8: EOT with valid pad, NAK with invalid pad.
        send(8'h16, 0);
        expect_b(8'h04, 1, 1, 0, "R8 EOT"); send(8'h04, 0);
        chk(hunting == 1'b0, "R8 waiting pad", hunting, 0);
        send(8'hFF, 0);
        drain("R8 valid pad");
        chk(pad_cnt == 0, "R8 good pad no error", pad_cnt, 0);
        send(8'h16, 0);
        expect_b(8'h15, 1, 1, 0, "R8 NAK"); send(8'h15, 0);
        send(8'h55, 0);
        drain("R8 invalid pad");
        chk(pad_cnt == 1, "R8 bad pad error", pad_cnt, 1);

        // R9: EBCDIC codes; ASCII sync and ETX-like values.
        cfg_ascii = 1'b0; cfg_two_syn = 1'b1;
        send(8'h16, 0);
        chk(hunting == 1'b1, "R9 ASCII sync ignored", hunting, 1);
        send(8'h32, 0); send(8'h32, 0); send(8'h32, 0);
        expect_b(8'h02, 1, 0, 0, "R9 first"); send(8'h02, 0);
        expect_b(8'h16, 0, 0, 0, "R9 ASCII SYN data"); send(8'h16, 0);
        expect_b(8'h17, 0, 0, 0, "R9 ASCII ETB data"); send(8'h17, 0);
        expect_b(8'h26, 0, 1, 0, "R9 EBCDIC ETB eom"); send(8'h26, 0);
        drain("R9 EBCDIC end");
        send(8'h32, 0); send(8'h32, 0);
        expect_b(8'h37, 1, 1, 0, "R9 EBCDIC EOT"); send(8'h37, 0);
        send(8'h0F, 0);
        drain("R9 EBCDIC pad");
        chk(pad_cnt == 1, "R8 pad 0F valid", pad_cnt, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule